// File: doc/BRIEF.md
# Drift-Corrected Schedule Delta Generator

This block produces the strobe that steps a time-aware egress schedule sequencer forward. It runs on the scheduler tick clock, where one clock cycle is one tick of 8 ns. It cuts that tick stream into deltas of nominally 25 ticks (200 ns). A time-of-day value in nanoseconds is supplied from a separately rate-corrected clock, and the block keeps the average delta in step with it. Over a programmable correction period, measured in time-of-day nanoseconds, it compares the ticks it actually counted with the ticks the reference says have elapsed. The signed difference is then spent by shortening or lengthening the deltas that follow, a whole tick at a time.

The generator waits until the time-of-day value reaches a programmed start time. It then emits a one-cycle strobe at the end of every delta, together with the length of the delta in progress. A synchronous halt input returns it to idle, clears all measurement and correction state, and keeps the strobe low. Only control pins are involved, with no data stream, so the block has no valid/ready handshake.

Top module: `sched_delta_gen`

## Requirements
- R1: After reset and while idle, `delta_stb_o` is 0 and `delta_len_o` reads the nominal length, 25.
- R2: The first cycle in which `halt_i` is 0 and `tod_i >= start_time_i` is launch cycle 0. The first strobe comes in cycle 25 after launch, and each strobe lasts exactly one cycle.
- R3: When `tod_i` advances exactly 8 per cycle, every delta is 25 cycles long and reports length 25, including across period boundaries.
- R4: No delta is shorter than 20 or longer than 30 ticks. Each delta departs from nominal by at most 5 ticks.
- R5: A period boundary occurs in the first cycle in which `tod_i` minus the period anchor is at least `corr_period_i`. The drift is floor(elapsed/8) minus the cycles counted since the anchor. That cycle becomes the new anchor, and deltas already in progress are not altered.
- R6: A positive drift shortens the next deltas by min(residual, 5) ticks each. The remainder carries over from delta to delta until it reaches 0, and deltas then return to 25.
- R7: A negative drift lengthens the next deltas by min(|residual|, 5) ticks each, carried the same way.
- R8: When a period boundary falls in the same cycle as a strobe, the delta starting next already uses the drift just measured.
- R9: While `halt_i` is 1 the strobe stays 0 and `delta_len_o` reads 25. On release, the generator launches afresh, with no residual and a new anchor.
- R10: At every strobe, `delta_len_o` equals the number of cycles since the previous strobe, or since launch for the first delta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scheduler tick clock, one tick per cycle |
| rst_ni | input | 1 | Active-low reset |
| halt_i | input | 1 | Synchronous stop: return to idle and clear state |
| tod_i | input | TOD_W | Rate-corrected time of day, ns |
| start_time_i | input | TOD_W | Time of day at which deltas begin |
| corr_period_i | input | TOD_W | Correction period length, ns |
| delta_stb_o | output | 1 | One-cycle strobe at the end of each delta |
| delta_len_o | output | LEN_W | Length in ticks of the current delta |

## Verification
Two functions can fall in the same cycle: the end of a delta, which consumes residual correction, and a period boundary, which produces a fresh drift. The bench provokes this by choosing a 2040 ns period and injecting a +40 ns step into the reference early in the period. That places the boundary exactly on the tenth strobe with a drift of +5. The verdict is the next strobe, which must come 20 cycles later rather than 25. Other cases place the boundary mid-delta, where the correction has to wait for the following delta.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  function automatic int sdg_clip(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int sdg_abs(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/sdg_drift_meter.sv
module sdg_drift_meter #(
  parameter int TOD_W    = 48,
  parameter int CNT_W    = 16,
  parameter int RES_W    = 16,
  parameter int NS_SHIFT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    launch_i,
  input  logic                    run_i,
  input  logic [TOD_W-1:0]        tod_i,
  input  logic [TOD_W-1:0]        period_i,
  output logic                    edge_o,
  output logic signed [RES_W-1:0] drift_o
);

  localparam logic signed [TOD_W:0] HI = $signed({{(TOD_W+2-RES_W){1'b0}}, {(RES_W-1){1'b1}}});
  localparam logic signed [TOD_W:0] LO = -HI - 1;

  logic [TOD_W-1:0] anchor_q;
  logic [CNT_W-1:0] ticks_q;
  logic [TOD_W-1:0] elapsed;
  logic signed [TOD_W:0] diff;

  always_comb begin
    elapsed = tod_i - anchor_q;
    edge_o  = run_i && (elapsed >= period_i);
    diff    = $signed({1'b0, elapsed >> NS_SHIFT})
            - $signed({{(TOD_W+1-CNT_W){1'b0}}, ticks_q});
    if (diff > HI)      drift_o = HI[RES_W-1:0];
    else if (diff < LO) drift_o = LO[RES_W-1:0];
    else                drift_o = diff[RES_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      anchor_q <= '0;
      ticks_q  <= '0;
    end else if (launch_i) begin
      anchor_q <= tod_i;
      ticks_q  <= CNT_W'(1);
    end else if (run_i) begin
      if (edge_o) begin
        anchor_q <= tod_i;
        ticks_q  <= CNT_W'(1);
      end else if (ticks_q != '1) begin
        ticks_q  <= ticks_q + 1'b1;
      end
    end
  end

  // R5: a boundary restarts the tick count of the new period
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (ticks_q == CNT_W'(1)));

endmodule

// File: rtl/sdg_trim_alloc.sv
module sdg_trim_alloc #(
  parameter int RES_W    = 16,
  parameter int MAX_TRIM = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    edge_i,
  input  logic signed [RES_W-1:0] drift_i,
  input  logic                    take_i,
  output logic signed [RES_W-1:0] trim_o
);

  logic signed [RES_W-1:0] resid_q;
  logic signed [RES_W-1:0] src;

  always_comb begin
    src    = edge_i ? drift_i : resid_q;
    trim_o = RES_W'(sdg_pkg::sdg_clip(int'(src), MAX_TRIM));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      resid_q <= '0;
    else if (clear_i) resid_q <= '0;
    else if (take_i)  resid_q <= src - trim_o;
    else if (edge_i)  resid_q <= drift_i;
  end

  // R6: spending a delta's trim never grows the outstanding residual
  p_resid_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !edge_i && !clear_i) |=>
      (sdg_pkg::sdg_abs(int'(resid_q)) <= sdg_pkg::sdg_abs(int'($past(resid_q)))));

endmodule

// File: rtl/sdg_delta_timer.sv
module sdg_delta_timer #(
  parameter int LEN_W     = 5,
  parameter int RES_W     = 16,
  parameter int NOM_TICKS = 25,
  parameter int MAX_TRIM  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    launch_i,
  input  logic                    run_i,
  input  logic signed [RES_W-1:0] trim_i,
  output logic                    stb_o,
  output logic [LEN_W-1:0]        len_o
);

  localparam logic [LEN_W-1:0] LEN_NOM = LEN_W'(NOM_TICKS);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(NOM_TICKS - MAX_TRIM);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(NOM_TICKS + MAX_TRIM);

  logic [LEN_W-1:0] phase_q, len_q, nxt_len;
  logic signed [31:0] len_calc;

  always_comb begin
    stb_o    = run_i && (phase_q == len_q - 1'b1);
    len_calc = NOM_TICKS - int'(trim_i);
    nxt_len  = len_calc[LEN_W-1:0];
    len_o    = len_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      len_q   <= LEN_NOM;
    end else if (clear_i || launch_i) begin
      phase_q <= '0;
      len_q   <= LEN_NOM;
    end else if (run_i) begin
      if (stb_o) begin
        phase_q <= '0;
        len_q   <= nxt_len;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  // R4: delta length stays inside the trim window
  p_len_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q >= LEN_MIN) && (len_q <= LEN_MAX));

  // R2: the strobe is a single-cycle pulse
  p_stb_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);

endmodule

// File: rtl/sched_delta_gen.sv
module sched_delta_gen #(
  parameter int TOD_W     = 48,
  parameter int CNT_W     = 16,
  parameter int RES_W     = 16,
  parameter int NOM_TICKS = 25,
  parameter int MAX_TRIM  = 5,
  parameter int NS_SHIFT  = 3,
  localparam int LEN_W    = $clog2(NOM_TICKS + MAX_TRIM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic [TOD_W-1:0] tod_i,
  input  logic [TOD_W-1:0] start_time_i,
  input  logic [TOD_W-1:0] corr_period_i,
  output logic             delta_stb_o,
  output logic [LEN_W-1:0] delta_len_o
);

  logic running_q;
  logic launch, run, bnd;
  logic signed [RES_W-1:0] drift, trim;

  assign launch = !running_q && !halt_i && (tod_i >= start_time_i);
  assign run    = running_q && !halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     running_q <= 1'b0;
    else if (halt_i) running_q <= 1'b0;
    else if (launch) running_q <= 1'b1;
  end

  sdg_drift_meter #(
    .TOD_W(TOD_W), .CNT_W(CNT_W), .RES_W(RES_W), .NS_SHIFT(NS_SHIFT)
  ) meter_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .run_i(run),
    .tod_i(tod_i), .period_i(corr_period_i), .edge_o(bnd), .drift_o(drift)
  );

  sdg_trim_alloc #(
    .RES_W(RES_W), .MAX_TRIM(MAX_TRIM)
  ) alloc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(halt_i), .edge_i(bnd),
    .drift_i(drift), .take_i(delta_stb_o), .trim_o(trim)
  );

  sdg_delta_timer #(
    .LEN_W(LEN_W), .RES_W(RES_W), .NOM_TICKS(NOM_TICKS), .MAX_TRIM(MAX_TRIM)
  ) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(halt_i), .launch_i(launch),
    .run_i(run), .trim_i(trim), .stb_o(delta_stb_o), .len_o(delta_len_o)
  );

  // R9: a halted cycle is followed by a quiet strobe
  p_halt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !delta_stb_o);

  // R2: launch starts a nominal delta with no strobe in its first cycle
  p_launch_nominal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (delta_len_o == LEN_W'(NOM_TICKS)) && !delta_stb_o);

endmodule

// File: tb/sched_delta_gen_tb_top.sv
`timescale 1ns/1ps
module sched_delta_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b1;
  logic [47:0] tod = 48'd1000;
  logic [47:0] start_t = '1;
  logic [47:0] period = 48'd2000;
  logic        stb;
  logic [4:0]  len;

  int n_vec = 0, n_bad = 0;
  int jcnt = 0;
  bit started = 0;
  int kick_j = -1;
  longint kick_v = 0;
  bit watch_halt = 0;
  bit done = 0;

  int    q_j[$];
  int    q_len[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  sched_delta_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .tod_i(tod),
    .start_time_i(start_t), .corr_period_i(period),
    .delta_stb_o(stb), .delta_len_o(len)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic push(input int j, input int l, input string tag);
    q_j.push_back(j);
    q_len.push_back(l);
    q_tag.push_back(tag);
  endtask

  task automatic push_nominal(input int upto, input string tag);
    for (int j = 25; j <= upto; j += 25) push(j, 25, tag);
  endtask

  // monitor: advances the reference clock and scores strobes
  always @(negedge clk) begin
    tod = tod + 48'd8;
    if (rst_n) begin
      if (halt) started = 0;
      else if (started) begin
        jcnt++;
        if (jcnt == kick_j) tod = tod + kick_v[47:0];
      end else if (tod >= start_t) begin
        started = 1;
        jcnt = 0;
      end
      if (halt && watch_halt) begin
        n_vec++;
        if (stb !== 1'b0 || len !== 5'd25) begin
          n_bad++;
          $display("FAIL R9: halted stb=%0b len=%0d expected stb=0 len=25", stb, len);
        end
      end
      if (stb === 1'b1) begin
        if (q_j.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R2: unexpected strobe at j=%0d expected none", jcnt);
        end else begin
          int ej, el;
          string et;
          ej = q_j.pop_front(); el = q_len.pop_front(); et = q_tag.pop_front();
          n_vec++;
          if (jcnt != ej) begin
            n_bad++;
            $display("FAIL %s: strobe at j=%0d expected j=%0d", et, jcnt, ej);
          end
          n_vec++;
          if (len != el[4:0]) begin
            n_bad++;
            $display("FAIL R10/%s: len=%0d at j=%0d expected %0d", et, len, jcnt, el);
          end
        end
      end
    end
  end

  task automatic arm(input int per, input int kj, input longint kv);
    @(posedge clk); #1;
    halt = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    period = 48'(per);
    kick_j = kj;
    kick_v = kv;
    start_t = tod + 48'd40;
    halt = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 1500 && q_j.size() != 0; i++) @(posedge clk);
    if (q_j.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL %s: %0d strobes missing, next expected j=%0d", tag, q_j.size(), q_j[0]);
      q_j.delete(); q_len.delete(); q_tag.delete();
    end
  endtask

  initial begin
    repeat (1000000 / 5) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2: watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    n_vec++;
    if (stb !== 1'b0 || len !== 5'd25) begin
      n_bad++;
      $display("FAIL R1: after reset stb=%0b len=%0d expected stb=0 len=25", stb, len);
    end

    // steady reference: all deltas nominal (R2, R3)
    push(25, 25, "R2");
    for (int j = 50; j <= 300; j += 25) push(j, 25, "R3");
    arm(2000, -1, 0);
    drain("R3");

    // reference 56 ns ahead: boundary at j=243, drift +7 (R5, R6, R4)
    push_nominal(250, "R5");
    push(270, 20, "R4");
    push(293, 23, "R6");
    push(318, 25, "R6");
    push(343, 25, "R6");
    arm(2000, 100, 56);
    drain("R6");

    // reference 56 ns behind: boundary at j=257, drift -7 (R5, R7, R4)
    push_nominal(275, "R5");
    push(305, 30, "R4");
    push(332, 27, "R7");
    push(357, 25, "R7");
    arm(2000, 100, -56);
    drain("R7");

    // boundary coincides with strobe at j=250, drift +5 (R8)
    push_nominal(250, "R8");
    push(270, 20, "R8");
    push(295, 25, "R8");
    arm(2040, 100, 40);
    drain("R8");

    // halt mid-run, then relaunch from scratch (R9)
    push(25, 25, "R9");
    push(50, 25, "R9");
    arm(2000, -1, 0);
    while (!(started && jcnt >= 60)) @(posedge clk);
    #1 halt = 1'b1;
    watch_halt = 1'b1;
    push(25, 25, "R9");
    push(50, 25, "R9");
    repeat (4) @(posedge clk);
    #1 halt = 1'b0;
    watch_halt = 1'b0;
    drain("R9");

    @(posedge clk); #1 halt = 1'b1;
    repeat (5) @(posedge clk);
    done = 1;
    report();
  end

endmodule